// File: doc/BRIEF.md
# DAC Clamp and Direct-Write Controller

This block feeds the 16-bit input code of an audio DAC. A host sample stream arrives with a one-cycle valid strobe. Each sample is compared, as an unsigned number, against a programmable ceiling. The registered DAC code takes the sample, or the ceiling when the sample is larger. The ceiling is held in two byte registers on a small byte-wide register bus. A third bus register carries a single trigger bit.

An external control nibble, `mode_i`, can select direct-write mode. In that mode the same byte pair stops acting as a ceiling and becomes a data word. A 1-to-0 transition of the trigger bit copies that word into the DAC code register. Firmware uses this at power-up to park the DAC at mid-scale (0x8000) so the speaker does not pop. Rising edges and repeated writes of the same trigger level do nothing.

Top module: `dac_clamp_ctrl`

## Requirements
- R1: After reset, `dac_code_o` is 0x8000, and reads of 0x2D, 0x2E and 0x2F all return 0x00.
- R2: A valid sample at or below the 16-bit ceiling {reg 0x2E, reg 0x2D} appears unchanged on `dac_code_o` one clock after its strobe.
- R3: A valid sample above the ceiling produces the ceiling on `dac_code_o` one clock after its strobe.
- R4: The comparison is unsigned, so sample 0x8000 against ceiling 0x7FFF yields 0x7FFF.
- R5: Reads of 0x2D and 0x2E return the last bytes written there. A read of 0x2F returns the trigger in bit 3 with all other bits 0. Unmapped addresses read 0x00.
- R6: When `mode_i` equals 4'b0101, a write to 0x2F that clears bit 3 while it is set loads {0x2E, 0x2D} into `dac_code_o` on that clock.
- R7: A write to 0x2F that sets bit 3, or that leaves it at its current level, does not change `dac_code_o`.
- R8: A falling trigger while `mode_i` is not 4'b0101 does not change `dac_code_o`.
- R9: When a direct load and a valid sample occur in the same cycle, the direct load wins.
- R10: With no valid sample and no direct load, `dac_code_o` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_addr_i | input | 8 | Register address |
| bus_wdata_i | input | 8 | Register write data |
| bus_we_i | input | 1 | Register write enable |
| bus_rdata_o | output | 8 | Register read data (combinational) |
| mode_i | input | 4 | Mode nibble from an external control register; 4'b0101 selects direct write |
| smp_valid_i | input | 1 | Host sample strobe |
| smp_data_i | input | 16 | Host sample, unsigned |
| dac_code_o | output | 16 | Registered DAC input code |

## Verification
The hardest case to reach is a direct load that coincides with a host sample strobe. It can only occur when the mode nibble is already 0101b and the trigger was set by an earlier write. The trigger-clearing write must then land in exactly the cycle that carries the sample. The stimulus first loads a pair value that differs from both the sample and the current code, arms the trigger, and then issues the clearing write and the strobe together. A behavioural model updated on every clock predicts which source wins.

// File: rtl/dac_clamp_pkg.sv
package dac_clamp_pkg;
  localparam int          ADDR_W      = 8;
  localparam int          BYTE_W      = 8;
  localparam logic [7:0]  ADDR_PAIR   = 8'h2D;
  localparam logic [7:0]  ADDR_TRIG   = 8'h2F;
  localparam int          TRIG_BIT    = 3;
  localparam logic [3:0]  MODE_DIRECT = 4'b0101;
endpackage

// File: rtl/dac_pair_regs.sv
module dac_pair_regs #(
  parameter int              ADDR_W    = 8,
  parameter int              BYTE_W    = 8,
  parameter int              NBYTES    = 2,
  parameter logic [ADDR_W-1:0] BASE_ADDR = '0,
  parameter logic [ADDR_W-1:0] TRIG_ADDR = '1,
  parameter int              TRIG_BIT  = 0,
  localparam int             PAIR_W    = NBYTES * BYTE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [BYTE_W-1:0] wdata_i,
  input  logic              we_i,
  output logic [BYTE_W-1:0] rdata_o,
  output logic [PAIR_W-1:0] pair_o,
  output logic              trig_o,
  output logic              trig_fall_o
);
  logic [BYTE_W-1:0] byte_q [NBYTES];
  logic              trig_q;

  for (genvar i = 0; i < NBYTES; i++) begin : g_byte
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                        byte_q[i] <= '0;
      else if (we_i && addr_i == ADDR_W'(BASE_ADDR + i))  byte_q[i] <= wdata_i;
    end
    assign pair_o[i*BYTE_W +: BYTE_W] = byte_q[i];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          trig_q <= 1'b0;
    else if (we_i && addr_i == TRIG_ADDR) trig_q <= wdata_i[TRIG_BIT];
  end

  // 1->0 on the trigger, detected on the write that clears it
  assign trig_fall_o = we_i && addr_i == TRIG_ADDR && trig_q && !wdata_i[TRIG_BIT];
  assign trig_o      = trig_q;

  always_comb begin
    rdata_o = '0;
    for (int i = 0; i < NBYTES; i++)
      if (addr_i == ADDR_W'(BASE_ADDR + i)) rdata_o = byte_q[i];
    if (addr_i == TRIG_ADDR) rdata_o[TRIG_BIT] = trig_q;
  end
endmodule

// File: rtl/dac_clamp_cmp.sv
module dac_clamp_cmp #(
  parameter int W = 16
) (
  input  logic [W-1:0] smp_i,
  input  logic [W-1:0] lim_i,
  output logic [W-1:0] out_o
);
  assign out_o = (smp_i > lim_i) ? lim_i : smp_i;
endmodule

// File: rtl/dac_clamp_ctrl.sv
module dac_clamp_ctrl
  import dac_clamp_pkg::*;
#(
  parameter int NBYTES = 2,
  localparam int DATA_W = NBYTES * BYTE_W,
  localparam logic [DATA_W-1:0] DAC_MID = DATA_W'(1) << (DATA_W - 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [BYTE_W-1:0] bus_wdata_i,
  input  logic              bus_we_i,
  output logic [BYTE_W-1:0] bus_rdata_o,
  input  logic [3:0]        mode_i,
  input  logic              smp_valid_i,
  input  logic [DATA_W-1:0] smp_data_i,
  output logic [DATA_W-1:0] dac_code_o
);
  logic [DATA_W-1:0] pair_w, clamped_w, dac_q;
  logic              trig_w, fall_w, commit_w;

  dac_pair_regs #(
    .ADDR_W(ADDR_W), .BYTE_W(BYTE_W), .NBYTES(NBYTES),
    .BASE_ADDR(ADDR_PAIR), .TRIG_ADDR(ADDR_TRIG), .TRIG_BIT(TRIG_BIT)
  ) u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .addr_i(bus_addr_i), .wdata_i(bus_wdata_i), .we_i(bus_we_i),
    .rdata_o(bus_rdata_o), .pair_o(pair_w),
    .trig_o(trig_w), .trig_fall_o(fall_w)
  );

  dac_clamp_cmp #(.W(DATA_W)) u_cmp (
    .smp_i(smp_data_i), .lim_i(pair_w), .out_o(clamped_w)
  );

  assign commit_w = fall_w && (mode_i == MODE_DIRECT);

  // direct load outranks a same-cycle sample
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          dac_q <= DAC_MID;
    else if (commit_w)    dac_q <= pair_w;
    else if (smp_valid_i) dac_q <= clamped_w;
  end

  assign dac_code_o = dac_q;
endmodule

// File: rtl/dac_clamp_ctrl_chk.sv
module dac_clamp_ctrl_chk #(
  parameter int W = 16
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic [7:0]   bus_addr_i,
  input logic [7:0]   bus_wdata_i,
  input logic         bus_we_i,
  input logic [7:0]   bus_rdata_o,
  input logic [3:0]   mode_i,
  input logic         smp_valid_i,
  input logic [W-1:0] smp_data_i,
  input logic [W-1:0] dac_code_o,
  input logic [W-1:0] pair_i,
  input logic         trig_i
);
  logic load_c;
  assign load_c = bus_we_i && bus_addr_i == 8'h2F && trig_i && !bus_wdata_i[3]
                  && mode_i == 4'b0101;

  a_r6_direct_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_c |=> dac_code_o == $past(pair_i));

  a_r3_never_above: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (smp_valid_i && !load_c) |=> dac_code_o <= $past(pair_i));

  a_r2_pass_through: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (smp_valid_i && !load_c && smp_data_i <= pair_i) |=> dac_code_o == $past(smp_data_i));

  a_r10_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!smp_valid_i && !load_c) |=> $stable(dac_code_o));

  a_r5_trig_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_addr_i == 8'h2F |-> (bus_rdata_o[7:4] == 4'h0 && bus_rdata_o[2:0] == 3'h0));
endmodule

bind dac_clamp_ctrl dac_clamp_ctrl_chk #(.W(DATA_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .bus_addr_i(bus_addr_i), .bus_wdata_i(bus_wdata_i),
  .bus_we_i(bus_we_i), .bus_rdata_o(bus_rdata_o), .mode_i(mode_i),
  .smp_valid_i(smp_valid_i), .smp_data_i(smp_data_i), .dac_code_o(dac_code_o),
  .pair_i(pair_w), .trig_i(trig_w)
);

// File: tb/tb_dac_clamp_ctrl.sv
module tb_dac_clamp_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  bus_addr = '0, bus_wdata = '0, bus_rdata;
  logic        bus_we = 1'b0;
  logic [3:0]  mode = 4'h0;
  logic        smp_valid = 1'b0;
  logic [15:0] smp_data = '0, dac_code;

  int total = 0, bad = 0;
  bit done = 1'b0;

  // reference model state
  logic [7:0]  m_lo = '0, m_hi = '0;
  bit          m_trig = 1'b0;
  logic [15:0] m_dac = 16'h8000;

  always #5 clk = ~clk;

  dac_clamp_ctrl dut (
    .clk_i(clk), .rst_ni(rst_n),
    .bus_addr_i(bus_addr), .bus_wdata_i(bus_wdata), .bus_we_i(bus_we),
    .bus_rdata_o(bus_rdata), .mode_i(mode),
    .smp_valid_i(smp_valid), .smp_data_i(smp_data), .dac_code_o(dac_code)
  );

  task automatic check(input logic [15:0] act, input logic [15:0] exp, input string tag);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(input bit we, input logic [7:0] a, input logic [7:0] wd,
                      input bit v, input logic [15:0] s, input string tag);
    logic [15:0] pair;
    bit fall;
    bus_we = we; bus_addr = a; bus_wdata = wd; smp_valid = v; smp_data = s;
    @(posedge clk); #1;
    pair = {m_hi, m_lo};
    fall = we && a == 8'h2F && m_trig && !wd[3];
    if (fall && mode == 4'b0101) m_dac = pair;
    else if (v)                  m_dac = (s > pair) ? pair : s;
    if (we) begin
      if (a == 8'h2D) m_lo = wd;
      if (a == 8'h2E) m_hi = wd;
      if (a == 8'h2F) m_trig = wd[3];
    end
    bus_we = 1'b0; smp_valid = 1'b0;
    check(dac_code, m_dac, tag);
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] wd, input string tag);
    step(1'b1, a, wd, 1'b0, 16'h0, tag);
  endtask

  task automatic smp(input logic [15:0] s, input string tag);
    step(1'b0, 8'h00, 8'h00, 1'b1, s, tag);
  endtask

  task automatic rd(input logic [7:0] a, input string tag);
    logic [7:0] exp;
    bus_addr = a; #1;
    case (a)
      8'h2D:   exp = m_lo;
      8'h2E:   exp = m_hi;
      8'h2F:   exp = {4'h0, m_trig, 3'h0};
      default: exp = 8'h00;
    endcase
    check({8'h00, bus_rdata}, {8'h00, exp}, tag);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    check(dac_code, 16'h8000, "R1 dac");
    rd(8'h2D, "R1 lo"); rd(8'h2E, "R1 hi"); rd(8'h2F, "R1 trig");
    rst_n = 1'b1;
    step(1'b0, 8'h00, 8'h00, 1'b0, 16'h0, "R10 idle after reset");

    // R5 program ceiling 0xFF00
    wr(8'h2D, 8'h00, "R5 wr lo"); wr(8'h2E, 8'hFF, "R5 wr hi");
    rd(8'h2D, "R5 lo"); rd(8'h2E, "R5 hi"); rd(8'h40, "R5 unmapped");

    smp(16'h1234, "R2 below");
    smp(16'hFF00, "R2 equal");
    smp(16'hFFFF, "R3 above");
    step(1'b0, 8'h00, 8'h00, 1'b0, 16'h0001, "R10 hold");
    step(1'b0, 8'h00, 8'h00, 1'b0, 16'h0002, "R10 hold");

    // R4 unsigned
    wr(8'h2D, 8'hFF, "R4 wr lo"); wr(8'h2E, 8'h7F, "R4 wr hi");
    smp(16'h8000, "R4 unsigned clamp");
    smp(16'h7FFE, "R2 below 7FFF");
    smp(16'h0000, "R2 zero");

    // R5 / R7 trigger register
    wr(8'h2F, 8'h08, "R7 rising");
    rd(8'h2F, "R5 trig set");
    wr(8'h2F, 8'hFF, "R7 steady");
    rd(8'h2F, "R5 trig other bits zero");

    // R8 falling in normal mode
    mode = 4'h3;
    wr(8'h2F, 8'h00, "R8 fall normal mode");
    rd(8'h2F, "R5 trig clear");

    // R6 direct write to mid-scale
    mode = 4'b0101;
    wr(8'h2D, 8'h00, "R6 wr lo"); wr(8'h2E, 8'h80, "R6 wr hi");
    wr(8'h2F, 8'h08, "R7 rising direct");
    wr(8'h2F, 8'h08, "R7 steady direct");
    wr(8'h2F, 8'h00, "R6 fall direct");
    wr(8'h2F, 8'h00, "R7 low steady");

    // R9 direct load beats a same-cycle sample
    wr(8'h2D, 8'h34, "R9 wr lo"); wr(8'h2E, 8'h12, "R9 wr hi");
    wr(8'h2F, 8'h08, "R9 arm");
    step(1'b1, 8'h2F, 8'h00, 1'b1, 16'h0001, "R9 collide");
    smp(16'hAAAA, "R3 direct mode clamp");
    mode = 4'h0;
    smp(16'h0777, "R2 back to normal");

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule